// File: doc/BRIEF.md
# Programmable Interrupt Controller with IRQ/FIQ Routing

This block gathers a set of external interrupt lines (32 by default) and turns them into two requests for a processor: an ordinary interrupt request and a fast interrupt request. Each line first passes through a two-flop synchronizer. Each line then has its own detection setting: level-sensitive or edge-triggered, with either polarity. Edge events are held in a latch until software acknowledges them. A per-line enable mask gates the pending state. A per-line routing bit chooses which of the two requests a pending line drives.

Software reaches six 32-bit registers through a plain synchronous bus. There is a select, a write strobe, a byte address and write data. Read data appears on the cycle after a read strobe and holds until the next read. The bus is a control port, so it has no back-pressure: every strobe completes in one cycle. To cascade two instances, wire the request output of one into a source input of the other.

Top module: `intc_ctrl`

## Requirements
- R1: After reset the enable, polarity, type and routing registers read 0, so every line is disabled, level-sensitive and active-low. Both request outputs are 0.
- R2: The registers sit at these byte offsets: enable 0x00, raw pending 0x04, masked pending 0x08, polarity 0x0C, type 0x10, routing 0x14. Bit i belongs to source i. Enable, polarity, type and routing read back what was written. Read data is valid on the cycle after the read strobe.
- R3: With type bit 0 (level), the raw bit is 1 exactly when the synchronized input equals the polarity bit, so polarity 1 means active-high. Writes to the raw register leave a level bit unchanged.
- R4: With type bit 1 (edge), polarity 1 latches a rising edge and polarity 0 latches a falling edge. The opposite edge sets nothing. A latched bit stays 1 after the input returns.
- R5: Writing 1 to a bit of the raw register clears that bit's edge latch. Writing 0 leaves it unchanged.
- R6: If an edge event and a clearing write reach the same bit in the same cycle, the bit stays 1.
- R7: The masked pending register reads as raw pending AND enable.
- R8: The IRQ output is the registered OR of masked pending bits whose routing bit is 0. The FIQ output is the registered OR of masked pending bits whose routing bit is 1. Each output changes one cycle after the state that feeds it.
- R9: Writes to the masked pending register, and writes to unmapped offsets, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Asynchronous interrupt source lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The level path is driven with a table of source, enable, polarity and routing patterns. The table includes all-zero and all-one inputs, mixed polarities that cancel to all-active, partly masked words, and patterns that steer only to FIQ or only to IRQ. These separate a polarity inversion error, a mask error and a routing error. Edge lines are driven with rising and falling transitions under both polarities, so a wrong edge direction shows up. Acknowledge writes are tried with 0-bits, with 1-bits, and with timing that lands on the same cycle as a new event, which checks the precedence rule.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam logic [7:0] OFF_ENABLE = 8'h00;
  localparam logic [7:0] OFF_RAW    = 8'h04;
  localparam logic [7:0] OFF_STAT   = 8'h08;
  localparam logic [7:0] OFF_POL    = 8'h0C;
  localparam logic [7:0] OFF_TYPE   = 8'h10;
  localparam logic [7:0] OFF_ROUTE  = 8'h14;

  typedef enum logic [2:0] {
    SEL_ENABLE,
    SEL_RAW,
    SEL_STAT,
    SEL_POL,
    SEL_TYPE,
    SEL_ROUTE,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [7:0] a);
    case (a)
      OFF_ENABLE: return SEL_ENABLE;
      OFF_RAW:    return SEL_RAW;
      OFF_STAT:   return SEL_STAT;
      OFF_POL:    return SEL_POL;
      OFF_TYPE:   return SEL_TYPE;
      OFF_ROUTE:  return SEL_ROUTE;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int N_SRC  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] async_i,
  output logic [N_SRC-1:0] sync_o,
  output logic [N_SRC-1:0] prev_o
);
  // stage 0 samples the pin, stage STAGES-1 is the synchronized value,
  // stage STAGES holds the previous synchronized value for edge detection
  localparam int DEPTH = STAGES + 1;

  logic [N_SRC-1:0] pipe [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe[g] <= '0;
        end else if (g == 0) begin
          pipe[g] <= async_i;
        end else begin
          pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign sync_o = pipe[STAGES-1];
  assign prev_o = pipe[STAGES];
endmodule

// File: rtl/intc_detect.sv
module intc_detect #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] sync_i,
  input  logic [N_SRC-1:0] prev_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] edge_mode_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] evt_o,
  output logic [N_SRC-1:0] raw_o
);
  logic [N_SRC-1:0] latch_q;

  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_src
      logic act_now;
      logic act_old;

      // polarity-adjusted views of the current and previous samples
      assign act_now  = pol_i[i] ? sync_i[i] : ~sync_i[i];
      assign act_old  = pol_i[i] ? prev_i[i] : ~prev_i[i];
      assign evt_o[i] = act_now & ~act_old;

      // a fresh event takes precedence over a clearing write
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          latch_q[i] <= 1'b0;
        end else begin
          latch_q[i] <= edge_mode_i[i] & (evt_o[i] | (latch_q[i] & ~clr_i[i]));
        end
      end

      assign raw_o[i] = edge_mode_i[i] ? latch_q[i] : act_now;
    end
  endgenerate
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  raw_i,
  output logic [N_SRC-1:0]  enable_o,
  output logic [N_SRC-1:0]  pol_o,
  output logic [N_SRC-1:0]  edge_mode_o,
  output logic [N_SRC-1:0]  route_o,
  output logic [N_SRC-1:0]  clr_o,
  output logic [N_SRC-1:0]  stat_o
);
  reg_sel_e         sel;
  logic             wr_en;
  logic             rd_en;
  logic [N_SRC-1:0] wbits;
  logic [N_SRC-1:0] rbits;
  logic [DATA_W-1:0] rword;

  assign sel   = decode_addr(8'(bus_addr));
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign wbits = bus_wdata[N_SRC-1:0];

  assign stat_o = raw_i & enable_o;
  assign clr_o  = (wr_en && sel == SEL_RAW) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o    <= '0;
      pol_o       <= '0;
      edge_mode_o <= '0;
      route_o     <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_ENABLE: enable_o    <= wbits;
        SEL_POL:    pol_o       <= wbits;
        SEL_TYPE:   edge_mode_o <= wbits;
        SEL_ROUTE:  route_o     <= wbits;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_ENABLE: rbits = enable_o;
      SEL_RAW:    rbits = raw_i;
      SEL_STAT:   rbits = stat_o;
      SEL_POL:    rbits = pol_o;
      SEL_TYPE:   rbits = edge_mode_o;
      SEL_ROUTE:  rbits = route_o;
      default:    rbits = '0;
    endcase
    rword = '0;
    rword[N_SRC-1:0] = rbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= rword;
    end
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  logic [N_SRC-1:0] sync_w;
  logic [N_SRC-1:0] prev_w;
  logic [N_SRC-1:0] evt_w;
  logic [N_SRC-1:0] raw_w;
  logic [N_SRC-1:0] enable_w;
  logic [N_SRC-1:0] pol_w;
  logic [N_SRC-1:0] type_w;
  logic [N_SRC-1:0] route_w;
  logic [N_SRC-1:0] clr_w;
  logic [N_SRC-1:0] stat_w;

  intc_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_in),
    .sync_o  (sync_w),
    .prev_o  (prev_w)
  );

  intc_detect #(.N_SRC(N_SRC)) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_w),
    .prev_i      (prev_w),
    .pol_i       (pol_w),
    .edge_mode_i (type_w),
    .clr_i       (clr_w),
    .evt_o       (evt_w),
    .raw_o       (raw_w)
  );

  intc_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .raw_i       (raw_w),
    .enable_o    (enable_w),
    .pol_o       (pol_w),
    .edge_mode_o (type_w),
    .route_o     (route_w),
    .clr_o       (clr_w),
    .stat_o      (stat_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
    end else begin
      irq_out <= |(stat_w & ~route_w);
      fiq_out <= |(stat_w & route_w);
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic              fiq_out,
  input logic [N_SRC-1:0]  raw_w,
  input logic [N_SRC-1:0]  evt_w,
  input logic [N_SRC-1:0]  enable_w,
  input logic [N_SRC-1:0]  type_w,
  input logic [N_SRC-1:0]  route_w,
  input logic [N_SRC-1:0]  clr_w
);
  logic stat_read;
  assign stat_read = bus_sel && !bus_wr && (8'(bus_addr) == intc_pkg::OFF_STAT);

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(type_w) |-> ((raw_w & $past(clr_w & type_w & ~evt_w)) == '0)); // R5

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(type_w) |-> ((raw_w & $past(evt_w & type_w)) == $past(evt_w & type_w))); // R6

  AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_read |=> (bus_rdata[N_SRC-1:0] == $past(raw_w & enable_w))); // R7

  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(raw_w & enable_w & ~route_w))); // R8

  AST_FIQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out == $past(|(raw_w & enable_w & route_w))); // R8
endmodule

bind intc_ctrl intc_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .fiq_out   (fiq_out),
  .raw_w     (raw_w),
  .evt_w     (evt_w),
  .enable_w  (enable_w),
  .type_w    (type_w),
  .route_w   (route_w),
  .clr_w     (clr_w)
);

// File: tb/test_intc_ctrl.sv
`timescale 1ns/1ps
module test_intc_ctrl;
  localparam logic [7:0] A_EN = 8'h00, A_RAW = 8'h04, A_STAT = 8'h08;
  localparam logic [7:0] A_POL = 8'h0C, A_TYP = 8'h10, A_RT = 8'h14;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] en;
    logic [31:0] pol;
    logic [31:0] rt;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{src: 32'h0000_0000, en: 32'hFFFF_FFFF, pol: 32'h0000_0000, rt: 32'h0000_0000},
    '{src: 32'hFFFF_FFFF, en: 32'hFFFF_FFFF, pol: 32'h0000_0000, rt: 32'h0000_0000},
    '{src: 32'h0000_00F0, en: 32'h0000_00FF, pol: 32'hFFFF_FFFF, rt: 32'h0000_0010},
    '{src: 32'h8000_0001, en: 32'h8000_0000, pol: 32'hFFFF_FFFF, rt: 32'h8000_0000},
    '{src: 32'h0000_FFFF, en: 32'hFFFF_0000, pol: 32'h0000_FFFF, rt: 32'h0000_0000},
    '{src: 32'h1234_5678, en: 32'h0000_0000, pol: 32'hA5A5_0F0F, rt: 32'h0F0F_0F0F}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intc_ctrl i_intc_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] act, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    rd(A_EN, d);  check("R1 enable", d, 32'h0);
    rd(A_POL, d); check("R1 polarity", d, 32'h0);
    rd(A_TYP, d); check("R1 type", d, 32'h0);
    rd(A_RT, d);  check("R1 routing", d, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    check("R1 fiq", {31'b0, fiq_out}, 32'h0);
    // R3 inputs low, active-low level: all raw bits set
    rd(A_RAW, d); check("R3 raw after reset", d, 32'hFFFF_FFFF);

    // R8 registered output timing
    wr(A_EN, 32'h0000_0001);
    check("R8 irq one cycle late", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R8 irq asserted", {31'b0, irq_out}, 32'h1);
    wr(A_EN, 32'h0);

    // table walk: level mode, R3 R7 R8
    for (int v = 0; v < NV; v++) begin
      wr(A_TYP, 32'h0);
      wr(A_EN, VECS[v].en);
      wr(A_POL, VECS[v].pol);
      wr(A_RT, VECS[v].rt);
      @(negedge clk);
      src_in = VECS[v].src;
      settle();
      act = ~(VECS[v].src ^ VECS[v].pol);
      st  = act & VECS[v].en;
      rd(A_RAW, d);  check("R3 level raw", d, act);
      rd(A_STAT, d); check("R7 masked", d, st);
      check("R8 irq", {31'b0, irq_out}, {31'b0, |(st & ~VECS[v].rt)});
      check("R8 fiq", {31'b0, fiq_out}, {31'b0, |(st & VECS[v].rt)});
    end

    // R2 readback
    wr(A_POL, 32'hDEAD_BEEF); rd(A_POL, d); check("R2 polarity readback", d, 32'hDEAD_BEEF);
    wr(A_RT, 32'h1357_9BDF);  rd(A_RT, d);  check("R2 routing readback", d, 32'h1357_9BDF);
    wr(A_EN, 32'h0F0F_00FF);  rd(A_EN, d);  check("R2 enable readback", d, 32'h0F0F_00FF);

    // R9 ignored writes
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(A_EN, d);  check("R9 enable untouched", d, 32'h0F0F_00FF);
    rd(A_POL, d); check("R9 polarity untouched", d, 32'hDEAD_BEEF);
    rd(A_TYP, d); check("R9 type untouched", d, 32'h0);

    // R3 raw write ignored in level mode
    wr(A_POL, 32'h0000_0001);
    @(negedge clk); src_in = 32'h0000_0001;
    settle();
    wr(A_RAW, 32'h0000_0001);
    rd(A_RAW, d); check("R3 level ignores ack", d[0], 1'b1);

    // R4 rising edge on bit 5, falling edge on bit 6
    wr(A_EN, 32'hFFFF_FFFF);
    wr(A_RT, 32'h0);
    @(negedge clk); src_in = 32'h0;
    settle();
    wr(A_POL, 32'h0000_0020);
    wr(A_TYP, 32'h0000_0060);
    settle();
    rd(A_RAW, d); check("R4 no event yet", d[6:5], 2'b00);
    @(negedge clk); src_in = 32'h0000_0060;
    settle();
    rd(A_RAW, d); check("R4 rise latched / rise ignored for falling", d[6:5], 2'b01);
    @(negedge clk); src_in = 32'h0;
    settle();
    rd(A_RAW, d); check("R4 held after return and fall latched", d[6:5], 2'b11);

    // R5 write-one-to-clear
    wr(A_RAW, 32'hFFFF_FF9F);
    rd(A_RAW, d); check("R5 zero bits keep latch", d[6:5], 2'b11);
    wr(A_RAW, 32'h0000_0020);
    rd(A_RAW, d); check("R5 one clears", d[6:5], 2'b10);

    // R6 event coincides with clear: bit 5 first re-armed, then a new rise
    // arrives on the same edge as the clearing write
    @(negedge clk); src_in = 32'h0000_0020;
    settle();
    @(negedge clk); src_in = 32'h0;
    settle();
    rd(A_RAW, d); check("R6 precondition set", d[5], 1'b1);
    @(negedge clk); src_in = 32'h0000_0020;
    @(negedge clk);
    wr(A_RAW, 32'h0000_0020);
    rd(A_RAW, d); check("R6 event beats clear", d[5], 1'b1);
    wr(A_RAW, 32'h0000_0020);
    rd(A_RAW, d); check("R6 later clear works", d[5], 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule